// File: doc/BRIEF.md
# Double-Buffer Stream Address Sequencer

This block holds the address state for one DMA stream. It keeps a peripheral address, two memory buffer base addresses and an item counter. For each transfer it gives a source and a destination address, chosen from the direction that was latched when the stream started. A transfer engine pulses `xfer_done` once for each item it moves. The block counts these pulses down. When the count reaches the end of the block, the block stops, reloads, or reloads and swaps the memory buffer, depending on the mode that was latched at start.

In double-buffer mode the block switches between the two memory buffers at every block end, and circular operation is always in effect. While such a stream runs, software may refill the idle buffer and point its register at new data. A write to the buffer that is in use has no effect. In every other mode all address registers are frozen while the stream is active. A start request with a direction that cannot run under the requested mode is refused, and an error flag is raised.

Top module: `dbuf_addr_seq`

## Requirements
- R1: After reset, `active`, `cfg_err`, `cur_tgt`, `blk_end`, `items_left`, `src_addr` and `dst_addr` are all zero.
- R2: Direction code 00 (peripheral to memory) gives `src_addr` = peripheral address and `dst_addr` = address of the buffer selected by `cur_tgt` (0 = buffer A, 1 = buffer B).
- R3: Direction code 01 (memory to peripheral) gives `src_addr` = selected buffer address and `dst_addr` = peripheral address.
- R4: Direction code 10 (memory to memory) is accepted when neither double-buffer nor circular mode is requested. It gives `src_addr` = peripheral address and `dst_addr` = selected buffer address.
- R5: A rising edge of `en_req` while inactive starts the stream if the configuration is legal. Direction 11 in any mode is illegal. Direction 10 with double-buffer or circular mode is illegal. An illegal request sets `cfg_err` and leaves `active` at 0. The next legal start clears `cfg_err`.
- R6: Outside double-buffer mode, writes to the peripheral address, buffer A, buffer B or the item count (select codes 0, 1, 2, 3) are ignored while `active` is 1.
- R7: In double-buffer mode, while `active` is 1, a write to the buffer not selected by `cur_tgt` is accepted and a write to the selected buffer is ignored.
- R8: The target bit (select code 4, `wr_data[0]`) can be written only while inactive, and it picks the first buffer. In double-buffer mode `cur_tgt` inverts at every block end. At all other times it holds its value.
- R9: A block ends on the `xfer_done` that arrives when `items_left` is 1. In circular or double-buffer mode the counter reloads the programmed count and the stream stays active. Otherwise `items_left` becomes 0 and `active` falls.
- R10: Each `xfer_done` while active with `items_left` above 1 decrements `items_left` by one.
- R11: Changes to `dir`, `dbuf_mode` and `circ_mode` while active have no effect on routing or mode. These inputs are latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 peripheral, 1 buffer A, 2 buffer B, 3 item count, 4 target bit |
| wr_data | input | ADDR_W | Write data |
| en_req | input | 1 | Stream enable request; a rising edge starts the stream, a low level stops it |
| dir | input | 2 | Transfer direction code |
| dbuf_mode | input | 1 | Double-buffer mode request |
| circ_mode | input | 1 | Circular mode request |
| xfer_done | input | 1 | One item transferred |
| active | output | 1 | Stream running |
| cfg_err | output | 1 | Last start request was refused |
| cur_tgt | output | 1 | Selected memory buffer |
| blk_end | output | 1 | Current `xfer_done` ends a block |
| items_left | output | CNT_W | Items remaining in the block |
| src_addr | output | ADDR_W | Source address |
| dst_addr | output | ADDR_W | Destination address |

## Verification
The hardest case to reach is a write to the idle buffer during a running double-buffer stream, followed by a swap that brings the new address onto the output. Only this sequence shows that a write which was ignored earlier did not leak through. The stimulus starts a double-buffer stream with a short block count. It writes both buffers while the stream runs and checks that the destination is unchanged. It then completes two blocks, so that each refilled buffer in turn becomes the one in use. A write to the target bit during the run is also checked to show it is ignored.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   typedef enum logic [2:0] {
      SEL_PERIPH = 3'd0,
      SEL_BUF_A  = 3'd1,
      SEL_BUF_B  = 3'd2,
      SEL_COUNT  = 3'd3,
      SEL_TGT    = 3'd4
   } reg_sel_e;

   typedef enum logic [1:0] {
      DIR_P2M = 2'b00,
      DIR_M2P = 2'b01,
      DIR_M2M = 2'b10,
      DIR_RSV = 2'b11
   } dir_e;

   function automatic logic cfg_illegal(input logic [1:0] d, input logic dbuf, input logic circ);
      return (d == DIR_RSV) || ((d == DIR_M2M) && (dbuf || circ));
   endfunction
endpackage

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
   import dbs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_req,
   input  logic [1:0] dir,
   input  logic       dbuf_mode,
   input  logic       circ_mode,
   input  logic       blk_end,
   input  logic       tgt_wr,
   input  logic       tgt_val,
   output logic       active,
   output logic       cfg_err,
   output logic       cur_tgt,
   output logic       start,
   output logic [1:0] run_dir,
   output logic       run_dbuf,
   output logic       run_circ
);
   logic en_q;
   logic rise;
   logic bad;

   assign rise  = en_req && !en_q;
   assign bad   = cfg_illegal(dir, dbuf_mode, circ_mode);
   assign start = rise && !active && !bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         active   <= 1'b0;
         cfg_err  <= 1'b0;
         cur_tgt  <= 1'b0;
         run_dir  <= DIR_P2M;
         run_dbuf <= 1'b0;
         run_circ <= 1'b0;
      end else begin
         en_q <= en_req;
         if (rise && !active)
            cfg_err <= bad;
         if (start) begin
            active   <= 1'b1;
            run_dir  <= dir;
            run_dbuf <= dbuf_mode;
            run_circ <= circ_mode | dbuf_mode;   // double buffering implies circular
         end else if (!en_req || (blk_end && !run_circ)) begin
            active <= 1'b0;
         end
         if (!active && tgt_wr)
            cur_tgt <= tgt_val;
         else if (blk_end && run_dbuf)
            cur_tgt <= ~cur_tgt;
      end
   end
endmodule

// File: rtl/dbs_addr_bank.sv
module dbs_addr_bank
   import dbs_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              active,
   input  logic              run_dbuf,
   input  logic              cur_tgt,
   output logic [ADDR_W-1:0] periph,
   output logic [ADDR_W-1:0] buf_a,
   output logic [ADDR_W-1:0] buf_b
);
   localparam int NBUF = 2;
   logic [ADDR_W-1:0] bufs [NBUF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         periph <= '0;
      else if (wr_en && (wr_sel == SEL_PERIPH) && !active)
         periph <= wr_data;
   end

   for (genvar b = 0; b < NBUF; b++) begin : g_buf
      logic sel_hit;
      logic idle_ok;
      assign sel_hit = wr_en && (wr_sel == 3'(int'(SEL_BUF_A) + b));
      // running double-buffer stream: only the idle buffer may change
      assign idle_ok = !active || (run_dbuf && (cur_tgt != 1'(b)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bufs[b] <= '0;
         else if (sel_hit && idle_ok)
            bufs[b] <= wr_data;
      end
   end

   assign buf_a = bufs[0];
   assign buf_b = bufs[1];
endmodule

// File: rtl/dbs_counter.sv
module dbs_counter
   import dbs_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             active,
   input  logic             start,
   input  logic             xfer_done,
   input  logic             run_circ,
   output logic [CNT_W-1:0] items_left,
   output logic             blk_end
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic [CNT_W-1:0] reload;

   assign blk_end = active && xfer_done && (items_left == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload     <= '0;
         items_left <= '0;
      end else if (start) begin
         items_left <= reload;
      end else if (!active) begin
         if (wr_en && (wr_sel == SEL_COUNT)) begin
            reload     <= wr_data;
            items_left <= wr_data;
         end
      end else if (xfer_done && (items_left != '0)) begin
         if (items_left == ONE)
            items_left <= run_circ ? reload : '0;
         else
            items_left <= items_left - ONE;
      end
   end
endmodule

// File: rtl/dbs_route.sv
module dbs_route
   import dbs_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        dir,
   input  logic              cur_tgt,
   input  logic [ADDR_W-1:0] periph,
   input  logic [ADDR_W-1:0] buf_a,
   input  logic [ADDR_W-1:0] buf_b,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr
);
   logic [ADDR_W-1:0] mem_sel, src_c, dst_c;

   assign mem_sel = cur_tgt ? buf_b : buf_a;

   always_comb begin
      unique case (dir)
         DIR_P2M: begin src_c = periph;  dst_c = mem_sel; end
         DIR_M2P: begin src_c = mem_sel; dst_c = periph;  end
         DIR_M2M: begin src_c = periph;  dst_c = mem_sel; end
         default: begin src_c = '0;      dst_c = '0;      end
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            src_addr <= '0;
            dst_addr <= '0;
         end else begin
            src_addr <= src_c;
            dst_addr <= dst_c;
         end
      end
   end else begin : g_comb
      assign src_addr = src_c;
      assign dst_addr = dst_c;
   end
endmodule

// File: rtl/dbuf_addr_seq.sv
module dbuf_addr_seq
   import dbs_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              en_req,
   input  logic [1:0]        dir,
   input  logic              dbuf_mode,
   input  logic              circ_mode,
   input  logic              xfer_done,
   output logic              active,
   output logic              cfg_err,
   output logic              cur_tgt,
   output logic              blk_end,
   output logic [CNT_W-1:0]  items_left,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr
);
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
      $error("dbuf_addr_seq: ADDR_W must lie in 8..64");
   end
   if (CNT_W < 1 || CNT_W > ADDR_W) begin : g_bad_cnt_w
      $error("dbuf_addr_seq: CNT_W must lie in 1..ADDR_W");
   end

   logic              start, run_dbuf, run_circ, tgt_wr;
   logic [1:0]        run_dir, route_dir;
   logic [ADDR_W-1:0] periph, buf_a, buf_b;

   assign tgt_wr    = wr_en && (wr_sel == SEL_TGT);
   assign route_dir = active ? run_dir : dir;

   dbs_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .en_req(en_req), .dir(dir),
      .dbuf_mode(dbuf_mode), .circ_mode(circ_mode), .blk_end(blk_end),
      .tgt_wr(tgt_wr), .tgt_val(wr_data[0]), .active(active),
      .cfg_err(cfg_err), .cur_tgt(cur_tgt), .start(start),
      .run_dir(run_dir), .run_dbuf(run_dbuf), .run_circ(run_circ)
   );

   dbs_addr_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .active(active), .run_dbuf(run_dbuf),
      .cur_tgt(cur_tgt), .periph(periph), .buf_a(buf_a), .buf_b(buf_b)
   );

   dbs_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data[CNT_W-1:0]), .active(active), .start(start),
      .xfer_done(xfer_done), .run_circ(run_circ),
      .items_left(items_left), .blk_end(blk_end)
   );

   dbs_route #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_route (
      .clk(clk), .rst_n(rst_n), .dir(route_dir), .cur_tgt(cur_tgt),
      .periph(periph), .buf_a(buf_a), .buf_b(buf_b),
      .src_addr(src_addr), .dst_addr(dst_addr)
   );
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              active,
   input logic              cfg_err,
   input logic              cur_tgt,
   input logic              blk_end,
   input logic              run_dbuf,
   input logic              run_circ,
   input logic              xfer_done,
   input logic              wr_en,
   input logic [2:0]        wr_sel,
   input logic [CNT_W-1:0]  items_left,
   input logic [ADDR_W-1:0] buf_a,
   input logic [ADDR_W-1:0] buf_b
);
   a_r5_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !active);

   a_r6_bufs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !run_dbuf) |=> ($stable(buf_a) && $stable(buf_b)));

   a_r7_active_buf_held: assert property (@(posedge clk) disable iff (!rst_n)
      (active && run_dbuf && !cur_tgt) |=> $stable(buf_a));

   a_r8_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_end && run_dbuf) |=> (cur_tgt != $past(cur_tgt)));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_end && !(wr_en && (wr_sel == 3'd4) && !active)) |=> $stable(cur_tgt));

   a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_end && run_circ) |=> (items_left != '0));

   a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_end && !run_circ) |=> (!active && (items_left == '0)));

   a_r10_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (active && xfer_done && (items_left > CNT_W'(1))) |=> (items_left == $past(items_left) - CNT_W'(1)));
endmodule

bind dbuf_addr_seq dbs_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .active(active), .cfg_err(cfg_err),
   .cur_tgt(cur_tgt), .blk_end(blk_end), .run_dbuf(run_dbuf),
   .run_circ(run_circ), .xfer_done(xfer_done), .wr_en(wr_en),
   .wr_sel(wr_sel), .items_left(items_left), .buf_a(buf_a), .buf_b(buf_b)
);

// File: tb/sim_dbuf_addr_seq.sv
module sim_dbuf_addr_seq;
   localparam int AW = 32;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_sel = '0;
   logic [AW-1:0] wr_data = '0;
   logic          en_req = 1'b0;
   logic [1:0]    dir = 2'b00;
   logic          dbuf_mode = 1'b0;
   logic          circ_mode = 1'b0;
   logic          xfer_done = 1'b0;
   logic          active, cfg_err, cur_tgt, blk_end;
   logic [CW-1:0] items_left;
   logic [AW-1:0] src_addr, dst_addr;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   dbuf_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .en_req(en_req), .dir(dir), .dbuf_mode(dbuf_mode),
      .circ_mode(circ_mode), .xfer_done(xfer_done), .active(active),
      .cfg_err(cfg_err), .cur_tgt(cur_tgt), .blk_end(blk_end),
      .items_left(items_left), .src_addr(src_addr), .dst_addr(dst_addr)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [AW-1:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic go(input logic [1:0] d, input logic db, input logic ci);
      @(negedge clk);
      dir = d; dbuf_mode = db; circ_mode = ci; en_req = 1'b1;
      @(negedge clk);
   endtask

   task automatic halt();
      @(negedge clk);
      en_req = 1'b0; dbuf_mode = 1'b0; circ_mode = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_xfer();
      @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 active", active, 0);
      chk("R1 cfg_err", cfg_err, 0);
      chk("R1 cur_tgt", cur_tgt, 0);
      chk("R1 blk_end", blk_end, 0);
      chk("R1 items_left", items_left, 0);
      chk("R1 src", src_addr, 0);
      chk("R1 dst", dst_addr, 0);
   endtask

   task automatic t_p2m();
      wr(3'd0, 32'h1000); wr(3'd1, 32'h2000); wr(3'd2, 32'h3000); wr(3'd3, 32'd3);
      go(2'b00, 1'b0, 1'b0);
      chk("R2 active", active, 1);
      chk("R2 src", src_addr, 32'h1000);
      chk("R2 dst", dst_addr, 32'h2000);
      pulse_xfer(); chk("R10 count 2", items_left, 2);
      pulse_xfer(); chk("R10 count 1", items_left, 1);
      pulse_xfer();
      chk("R9 stop count", items_left, 0);
      chk("R9 stop active", active, 0);
      halt();
   endtask

   task automatic t_m2p();
      wr(3'd4, 32'd1);
      chk("R8 tgt written", cur_tgt, 1);
      go(2'b01, 1'b0, 1'b0);
      chk("R3 src", src_addr, 32'h3000);
      chk("R3 dst", dst_addr, 32'h1000);
      halt();
      wr(3'd4, 32'd0);
      chk("R8 tgt back", cur_tgt, 0);
   endtask

   task automatic t_m2m();
      go(2'b10, 1'b0, 1'b0);
      chk("R4 active", active, 1);
      chk("R4 cfg_err", cfg_err, 0);
      chk("R4 src", src_addr, 32'h1000);
      chk("R4 dst", dst_addr, 32'h2000);
      wr(3'd1, 32'hAAAA);
      chk("R6 buf A frozen", dst_addr, 32'h2000);
      wr(3'd0, 32'h5555);
      chk("R6 periph frozen", src_addr, 32'h1000);
      @(negedge clk); dir = 2'b01; @(negedge clk);
      chk("R11 dir latched src", src_addr, 32'h1000);
      chk("R11 dir latched dst", dst_addr, 32'h2000);
      halt();
   endtask

   task automatic t_illegal();
      go(2'b10, 1'b1, 1'b0);
      chk("R5 m2m+dbuf err", cfg_err, 1);
      chk("R5 m2m+dbuf inactive", active, 0);
      halt();
      go(2'b11, 1'b0, 1'b0);
      chk("R5 rsv err", cfg_err, 1);
      chk("R5 rsv inactive", active, 0);
      halt();
      go(2'b10, 1'b0, 1'b1);
      chk("R5 m2m+circ err", cfg_err, 1);
      halt();
      go(2'b00, 1'b0, 1'b0);
      chk("R5 err cleared", cfg_err, 0);
      chk("R5 legal start", active, 1);
      halt();
   endtask

   task automatic t_dbuf();
      wr(3'd3, 32'd2);
      go(2'b00, 1'b1, 1'b0);
      chk("R2 dbuf dst A", dst_addr, 32'h2000);
      wr(3'd2, 32'h3300);
      wr(3'd1, 32'h2200);
      chk("R7 active buf held", dst_addr, 32'h2000);
      pulse_xfer(); pulse_xfer();
      chk("R8 swap to B", cur_tgt, 1);
      chk("R7 idle write took", dst_addr, 32'h3300);
      chk("R9 dbuf reload", items_left, 2);
      chk("R9 dbuf stays", active, 1);
      wr(3'd1, 32'h2200);
      wr(3'd4, 32'd0);
      chk("R8 tgt write ignored", cur_tgt, 1);
      pulse_xfer(); pulse_xfer();
      chk("R8 swap to A", cur_tgt, 0);
      chk("R7 refilled A", dst_addr, 32'h2200);
      halt();
   endtask

   task automatic t_circ();
      go(2'b01, 1'b0, 1'b1);
      pulse_xfer();
      chk("R10 circ dec", items_left, 1);
      pulse_xfer();
      chk("R9 circ reload", items_left, 2);
      chk("R9 circ stays", active, 1);
      chk("R8 no swap outside dbuf", cur_tgt, 0);
      halt();
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1;
      t_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_p2m();
      t_m2p();
      t_m2m();
      t_illegal();
      t_dbuf();
      t_circ();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule